// File: doc/BRIEF.md
# Serial Capture to SRAM with Readback Verification

This block takes bytes from a serial receiver and writes each one to an external asynchronous SRAM. A session's first byte goes to address 0, and every later byte goes to the next address. Each byte is also written, at the same address, into an on-chip mirror RAM. When the verify input is pulsed, the block reads back every address written in the current session, in ascending order. It compares each SRAM word with the mirror copy and reports either pass, or fail together with the first address that differs.

One FSM owns a single address register and the only set of SRAM strobes. The capture phase and the verify phase therefore never compete for the address lines. Every SRAM access keeps chip enable active for a fixed, parameterised number of clocks. All SRAM strobes and all status outputs come straight from flip-flops.

A session starts with the first byte accepted after reset or after a verify pass has begun. Bytes that arrive while an access is in flight are dropped. The serial byte rate is assumed to be far slower than one access.

Top module: `sram_capture_verify`

## Requirements
- R1: An accepted byte is written at address 0 if it opens a session, and otherwise at the address after the previous byte. The write starts on the clock edge that samples `rx_valid`. For 1+ACCESS_CYC cycles `sram_ce` is high and `sram_addr` and `sram_wdata` are constant. `sram_we` is high only during the last ACCESS_CYC of those cycles, and `sram_oe` stays low. The next cycle returns to idle with all strobes low.
- R2: A byte is dropped with no SRAM access, and the address does not advance, in either of two cases: it arrives while the block is not idle, or 2**ADDR_W bytes are already stored in the session.
- R3: A verify pass with N stored bytes reads addresses 0 to N-1 in order. Each read holds `sram_ce` and `sram_oe` high for 1+ACCESS_CYC cycles with `sram_we` low. It is followed by one compare cycle with all strobes low. The read data is sampled on the last cycle in which the strobes are high.
- R4: A verify request that arrives while a write is in progress is held. The pass starts in the cycle after the write returns to idle. If a byte and a request arrive together in idle, the byte is written first.
- R5: If every word matches, `verify_pass` rises with a `verify_done` pulse that lasts exactly one cycle, and `verify_fail` stays low.
- R6: On the first mismatch, the pass stops at once. `verify_done` pulses, `verify_fail` rises, and `fail_addr`, `fail_rdata` and `fail_expected` hold the address, the word read from the SRAM and the mirror word. No further address is read.
- R7: A verify request made when the session holds no bytes gives `verify_done` and `verify_pass` on the next cycle, with no SRAM access.
- R8: The byte that opens a new session clears `verify_pass` and `verify_fail` on the edge that accepts it. Flags and failure details otherwise hold until that byte or the next verify start.
- R9: While reset is high and right after it, `sram_ce`, `sram_we`, `sram_oe`, `verify_done`, `verify_pass` and `verify_fail` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe for a received byte |
| rx_data | input | DATA_W | Received byte |
| verify_req | input | 1 | Request for a readback pass, sampled every cycle |
| sram_addr | output | ADDR_W | SRAM address |
| sram_wdata | output | DATA_W | Data driven to the SRAM on writes |
| sram_rdata | input | DATA_W | Data returned by the SRAM on reads |
| sram_ce | output | 1 | Chip enable, active high |
| sram_we | output | 1 | Write enable, active high |
| sram_oe | output | 1 | Output enable, active high |
| verify_done | output | 1 | One-cycle pulse at the end of a verify pass |
| verify_pass | output | 1 | Last pass matched at every address |
| verify_fail | output | 1 | Last pass found a mismatch |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_rdata | output | DATA_W | SRAM word read at that address |
| fail_expected | output | DATA_W | Mirror word for that address |

## Verification
A wrong address register shows on `sram_addr` during the first access it affects: the write lands on the wrong location, or the read walks out of order. A timer or FSM fault changes the length of a strobe window, and the bench catches it on the very next clock, because it compares every strobe, address and data value once per cycle against the expected access sequence. A mirror or compare fault appears at `verify_done`: a false pass, a false fail, or wrong failure details. A lost session count appears as a pass that ends at the wrong address.

// File: rtl/scv_pkg.sv
package scv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_WRITE_WAIT,
    ST_VERIFY_RD,
    ST_VERIFY_WAIT,
    ST_COMPARE,
    ST_DONE
  } scv_state_t;
endpackage

// File: rtl/scv_mirror_ram.sv
// Simple dual-port mirror store: one write port, one registered read port.
module scv_mirror_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/scv_wait_timer.sv
// Down-counter that sets the length of each SRAM access window.
module scv_wait_timer #(
  parameter int CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expire
);
  localparam int CW = (CYC < 2) ? 1 : $clog2(CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= CW'(CYC - 1);
    else if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
  end

  assign expire = (cnt_q == '0);

  // R1/R3: after a load the window cannot end on the following cycle unless CYC is 1
  a_r1_window_len: assert property (@(posedge clk) disable iff (rst)
    (load && CYC > 1) |=> !expire);
endmodule

// File: rtl/scv_result_latch.sv
// Holds the outcome of the most recent verify pass.
module scv_result_latch #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              set_pass,
  input  logic              set_fail,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [DATA_W-1:0] cur_rdata,
  input  logic [DATA_W-1:0] cur_expected,
  output logic              pass_q,
  output logic              fail_q,
  output logic [ADDR_W-1:0] fail_addr_q,
  output logic [DATA_W-1:0] fail_rdata_q,
  output logic [DATA_W-1:0] fail_exp_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pass_q       <= 1'b0;
      fail_q       <= 1'b0;
      fail_addr_q  <= '0;
      fail_rdata_q <= '0;
      fail_exp_q   <= '0;
    end else begin
      if (clear) begin
        pass_q <= 1'b0;
        fail_q <= 1'b0;
      end
      if (set_pass) pass_q <= 1'b1;
      if (set_fail) begin
        fail_q       <= 1'b1;
        fail_addr_q  <= cur_addr;
        fail_rdata_q <= cur_rdata;
        fail_exp_q   <= cur_expected;
      end
    end
  end

  // R5/R6: a pass never ends both ways
  a_r6_pass_fail_excl: assert property (@(posedge clk) disable iff (rst)
    !(pass_q && fail_q));
  // R6: the failure details stay frozen until the next failure is recorded
  a_r6_detail_frozen: assert property (@(posedge clk) disable iff (rst)
    (fail_q && !set_fail) |=> ($stable(fail_addr_q) && $stable(fail_rdata_q)));
endmodule

// File: rtl/sram_capture_verify.sv
module sram_capture_verify #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int ACCESS_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              verify_req,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_wdata,
  input  logic [DATA_W-1:0] sram_rdata,
  output logic              sram_ce,
  output logic              sram_we,
  output logic              sram_oe,
  output logic              verify_done,
  output logic              verify_pass,
  output logic              verify_fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_rdata,
  output logic [DATA_W-1:0] fail_expected
);
  import scv_pkg::*;

  localparam int CNT_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(1 << ADDR_W);

  scv_state_t        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  count_q;
  logic              open_q, pend_q;
  logic [DATA_W-1:0] wdata_q, rd_q;
  logic              ce_q, we_q, oe_q, done_q;

  logic              full, accept, vstart, last_addr, mismatch, expire;
  logic [ADDR_W-1:0] base_addr;
  logic [DATA_W-1:0] mirror_rd;

  assign full      = open_q && (count_q == FULL_CNT);
  assign accept    = (state_q == ST_IDLE) && rx_valid && !full;
  assign vstart    = (state_q == ST_IDLE) && !accept && (pend_q || verify_req);
  assign base_addr = open_q ? count_q[ADDR_W-1:0] : '0;
  assign last_addr = ({1'b0, addr_q} == (count_q - CNT_W'(1)));
  assign mismatch  = (rd_q != mirror_rd);

  scv_wait_timer #(.CYC(ACCESS_CYC)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load   ((state_q == ST_WRITE) || (state_q == ST_VERIFY_RD)),
    .expire (expire)
  );

  scv_mirror_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mirror (
    .clk     (clk),
    .wr_en   (accept),
    .wr_addr (base_addr),
    .wr_data (rx_data),
    .rd_addr (addr_q),
    .rd_data (mirror_rd)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept)      state_d = ST_WRITE;
        else if (vstart) state_d = (count_q == '0) ? ST_DONE : ST_VERIFY_RD;
      end
      ST_WRITE:       state_d = ST_WRITE_WAIT;
      ST_WRITE_WAIT:  if (expire) state_d = ST_IDLE;
      ST_VERIFY_RD:   state_d = ST_VERIFY_WAIT;
      ST_VERIFY_WAIT: if (expire) state_d = ST_COMPARE;
      ST_COMPARE:     state_d = (mismatch || last_addr) ? ST_DONE : ST_VERIFY_RD;
      ST_DONE:        state_d = ST_IDLE;
      default:        state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      count_q <= '0;
      open_q  <= 1'b0;
      pend_q  <= 1'b0;
      wdata_q <= '0;
      rd_q    <= '0;
      ce_q    <= 1'b0;
      we_q    <= 1'b0;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ce_q    <= (state_d == ST_WRITE) || (state_d == ST_WRITE_WAIT) ||
                 (state_d == ST_VERIFY_RD) || (state_d == ST_VERIFY_WAIT);
      we_q    <= (state_d == ST_WRITE_WAIT);
      oe_q    <= (state_d == ST_VERIFY_RD) || (state_d == ST_VERIFY_WAIT);
      done_q  <= (state_d == ST_DONE);
      pend_q  <= vstart ? 1'b0 : (pend_q || verify_req);
      if (accept) begin
        addr_q  <= base_addr;
        wdata_q <= rx_data;
        open_q  <= 1'b1;
        if (!open_q) count_q <= '0;
      end
      if (state_q == ST_WRITE_WAIT && expire)
        count_q <= {1'b0, addr_q} + CNT_W'(1);
      if (vstart) begin
        addr_q <= '0;
        open_q <= 1'b0;
      end
      if (state_q == ST_VERIFY_WAIT && expire)
        rd_q <= sram_rdata;
      if (state_q == ST_COMPARE && !mismatch && !last_addr)
        addr_q <= addr_q + ADDR_W'(1);
    end
  end

  scv_result_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_result (
    .clk          (clk),
    .rst          (rst),
    .clear        ((accept && !open_q) || vstart),
    .set_pass     ((state_q == ST_COMPARE && !mismatch && last_addr) ||
                   (vstart && count_q == '0)),
    .set_fail     (state_q == ST_COMPARE && mismatch),
    .cur_addr     (addr_q),
    .cur_rdata    (rd_q),
    .cur_expected (mirror_rd),
    .pass_q       (verify_pass),
    .fail_q       (verify_fail),
    .fail_addr_q  (fail_addr),
    .fail_rdata_q (fail_rdata),
    .fail_exp_q   (fail_expected)
  );

  assign sram_addr   = addr_q;
  assign sram_wdata  = wdata_q;
  assign sram_ce     = ce_q;
  assign sram_we     = we_q;
  assign sram_oe     = oe_q;
  assign verify_done = done_q;

  // R1: a write strobe needs chip enable and never overlaps a read
  a_r1_we_with_ce: assert property (@(posedge clk) disable iff (rst)
    sram_we |-> (sram_ce && !sram_oe));
  // R3: output enable only inside an enabled access
  a_r3_oe_with_ce: assert property (@(posedge clk) disable iff (rst)
    sram_oe |-> sram_ce);
  // R1/R3: address and write data hold steady across one access window
  a_r1_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (sram_ce && $past(sram_ce)) |-> ($stable(sram_addr) && $stable(sram_wdata)));
  // R5: the end-of-pass pulse lasts one cycle
  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    verify_done |=> !verify_done);
  // R2: the stored count never exceeds the address space
  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    count_q <= FULL_CNT);
endmodule

// File: tb/test_sram_capture_verify.sv
module test_sram_capture_verify;
  localparam int AW  = 8;
  localparam int DW  = 8;
  localparam int ACC = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rx_valid = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic          verify_req = 1'b0;
  logic [AW-1:0] sram_addr;
  logic [DW-1:0] sram_wdata, sram_rdata;
  logic          sram_ce, sram_we, sram_oe;
  logic          verify_done, verify_pass, verify_fail;
  logic [AW-1:0] fail_addr;
  logic [DW-1:0] fail_rdata, fail_expected;

  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] sram_mem [256];
  int corrupt_addr = -1;
  logic [DW-1:0] exp_data [256];
  int exp_n = 0;
  bit exp_pass = 0, exp_fail = 0;

  always #5 clk = ~clk;

  sram_capture_verify #(.ADDR_W(AW), .DATA_W(DW), .ACCESS_CYC(ACC)) i_sram_capture_verify (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .verify_req(verify_req), .sram_addr(sram_addr), .sram_wdata(sram_wdata),
    .sram_rdata(sram_rdata), .sram_ce(sram_ce), .sram_we(sram_we), .sram_oe(sram_oe),
    .verify_done(verify_done), .verify_pass(verify_pass), .verify_fail(verify_fail),
    .fail_addr(fail_addr), .fail_rdata(fail_rdata), .fail_expected(fail_expected)
  );

  // External SRAM model
  always @(posedge clk) if (sram_ce && sram_we) sram_mem[sram_addr] <= sram_wdata;
  assign sram_rdata = (sram_ce && sram_oe)
      ? (sram_mem[sram_addr] ^ ((int'(sram_addr) == corrupt_addr) ? 8'hFF : 8'h00))
      : 8'h5A;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Called just after a negedge; checks every cycle of one write.
  task automatic send_byte(input logic [DW-1:0] d, input bit drop_mid, input bit vreq_mid);
    int a;
    if (exp_n == -1) begin exp_n = 0; exp_pass = 0; exp_fail = 0; end  // new session (R8)
    a = exp_n;
    rx_valid = 1'b1; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
    chk("R1 ce", sram_ce, 1); chk("R1 we setup", sram_we, 0); chk("R1 oe", sram_oe, 0);
    chk("R1 addr", sram_addr, a); chk("R1 wdata", sram_wdata, d);
    chk("R8 pass", verify_pass, exp_pass); chk("R8 fail", verify_fail, exp_fail);
    for (int i = 0; i < ACC; i++) begin
      @(negedge clk);
      rx_valid = 1'b0; verify_req = 1'b0;
      chk("R1 ce wait", sram_ce, 1); chk("R1 we", sram_we, 1); chk("R4 oe held off", sram_oe, 0);
      chk("R2 addr", sram_addr, a); chk("R1 wdata hold", sram_wdata, d);
      if (i == 0 && drop_mid) begin rx_valid = 1'b1; rx_data = 8'hEE; end
      if (i == 0 && vreq_mid) verify_req = 1'b1;
    end
    @(negedge clk);
    chk("R1 idle ce", sram_ce, 0); chk("R1 idle we", sram_we, 0);
    exp_data[a] = d;
    exp_n = a + 1;
  endtask

  task automatic run_verify(input bit pulse, input int fail_at);
    int stop;
    if (exp_n < 0) exp_n = 0;
    if (pulse) verify_req = 1'b1;
    if (exp_n == 0) begin
      @(negedge clk); verify_req = 1'b0;
      chk("R7 done", verify_done, 1); chk("R7 pass", verify_pass, 1);
      chk("R7 fail", verify_fail, 0); chk("R7 no access", sram_ce, 0);
    end else begin
      stop = (fail_at >= 0) ? fail_at : exp_n - 1;
      for (int a = 0; a <= stop; a++) begin
        @(negedge clk); verify_req = 1'b0;
        chk("R3 ce", sram_ce, 1); chk("R3 oe", sram_oe, 1);
        chk("R3 we", sram_we, 0); chk("R3 addr", sram_addr, a);
        for (int k = 0; k < ACC; k++) begin
          @(negedge clk);
          chk("R3 oe wait", sram_oe, 1); chk("R3 addr hold", sram_addr, a);
        end
        @(negedge clk);
        chk("R3 compare ce", sram_ce, 0); chk("R3 compare oe", sram_oe, 0);
        chk("R3 no early done", verify_done, 0);
      end
      @(negedge clk);
      chk("R5 done", verify_done, 1); chk("R3 no access", sram_ce, 0);
      if (fail_at >= 0) begin
        chk("R6 fail", verify_fail, 1); chk("R6 pass", verify_pass, 0);
        chk("R6 addr", fail_addr, fail_at);
        chk("R6 rdata", fail_rdata, exp_data[fail_at] ^ 8'hFF);
        chk("R6 expected", fail_expected, exp_data[fail_at]);
      end else begin
        chk("R5 pass", verify_pass, 1); chk("R5 fail", verify_fail, 0);
      end
    end
    exp_pass = (fail_at < 0); exp_fail = (fail_at >= 0);
    @(negedge clk);
    chk("R5 done one cycle", verify_done, 0);
    chk("R8 pass hold", verify_pass, exp_pass); chk("R8 fail hold", verify_fail, exp_fail);
    exp_n = -1;  // session closed; next byte opens a new one
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 ce", sram_ce, 0); chk("R9 we", sram_we, 0); chk("R9 oe", sram_oe, 0);
    chk("R9 done", verify_done, 0); chk("R9 pass", verify_pass, 0); chk("R9 fail", verify_fail, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 after release", sram_ce, 0);

    run_verify(1, -1);                               // empty session (R7)

    exp_n = -1;
    send_byte(8'h11, 0, 0);
    send_byte(8'h22, 1, 0);                          // byte arriving mid-write dropped (R2)
    send_byte(8'h33, 0, 0);
    send_byte(8'h44, 0, 0);
    send_byte(8'h55, 0, 0);
    for (int a = 0; a < 5; a++) chk("R1 stored", sram_mem[a], exp_data[a]);
    run_verify(1, -1);                               // R5

    send_byte(8'hA0, 0, 0);                          // new session from 0 (R8)
    send_byte(8'hA1, 0, 0);
    send_byte(8'hA2, 0, 0);
    send_byte(8'hA3, 0, 1);                          // request held during write (R4)
    run_verify(0, -1);

    corrupt_addr = 2;
    exp_n = 4;
    run_verify(1, 2);                                // R6
    corrupt_addr = -1;

    for (int i = 0; i < 256; i++) send_byte(DW'(i * 7 + 3), 0, 0);
    rx_valid = 1'b1; rx_data = 8'h99;                // one byte too many (R2)
    @(negedge clk); rx_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk("R2 full no access", sram_ce, 0);
      @(negedge clk);
    end
    chk("R2 last stored", sram_mem[255], exp_data[255]);
    run_verify(1, -1);

    finish_run();
  end
endmodule